// File: doc/BRIEF.md
# Command Mailbox Responder

This block is the device-side responder for a word-wide command mailbox kept in a small host-visible register file. Software first loads a subsystem code and up to `N_PARAM` parameter words. It then writes a command code into the low byte of the mailbox word and polls that same word until its high byte turns nonzero. The block decodes the command against the selected subsystem and carries out the action. The supported actions are a single analog sample read through a ready/valid converter port, a digital input read, a single analog output write strobe, a digital output update, per-subsystem run enables, and configure acknowledges. Any result is placed in parameter word 2. The block then rewrites the mailbox high byte with a completion code.

A zero high byte means the command is still pending. Three distinct byte patterns report success, a bad argument and an unsupported request. A command-done flag rises with every completion and stays set, together with the code, until software writes the mailbox again. A conversion that the converter never answers is cut off after a bounded number of cycles, so software that polls for a fixed time always sees a final code.

Top module: `mbx_responder`

## Requirements
- R1: Host addresses: 0 is the mailbox, 1 is the subsystem word, and 2+k is parameter k. A host write to the mailbox stores `wdata[7:0]` as the command code in bits 7:0. It forces bits 15:8 to 0x00 (pending) whatever `wdata[15:8]` holds, and it clears `cmd_done_irq`.
- R2: Every command completes by writing 0x55 (success), 0xAA (bad argument or no sample) or 0xFF (unsupported) into mailbox bits 15:8. It also sets `cmd_done_irq`. Both stay unchanged until the next host write to the mailbox.
- R3: Every command completes within `CONV_TIMEOUT`+2 cycles of the mailbox write. A conversion that `conv_vld` does not answer within `CONV_TIMEOUT` cycles completes with 0xAA, leaves parameter 2 unchanged and drops `conv_req`.
- R4: Read single (command 5) on analog in (subsystem 0) with channel = parameter 0 below `AI_CHANNELS` raises `conv_req`. While it waits, `conv_req` holds `conv_chan` = parameter 0 and `conv_gain` = parameter 1 bits 1:0 steady until `conv_vld`. It then stores the zero-extended `conv_data` in parameter 2 and completes with 0x55.
- R5: Read single on analog in with parameter 0 at or above `AI_CHANNELS` completes with 0xAA, raises no `conv_req` and leaves parameter 2 unchanged.
- R6: Read single on digital in (subsystem 2) stores the zero-extended `din` in parameter 2 and completes with 0x55.
- R7: Write single (command 6) on analog out (subsystem 1) with parameter 0 below `AO_CHANNELS` gives one `ao_wr_stb` pulse carrying `ao_chan` = parameter 0 and `ao_data` = parameter 2, and completes with 0x55. With parameter 0 out of range it completes with 0xAA and gives no pulse.
- R8: Write single on digital out (subsystem 3) loads `dout` with parameter 2 bits `DIO_W`-1:0 and completes with 0x55.
- R9: Start (command 3) sets and stop (command 4) clears `run_en[0]` for analog in and `run_en[1]` for analog out. Each completes with 0x55. Start or stop on any other subsystem completes with 0xFF and changes nothing.
- R10: Configure (command 1) on analog in, analog out or digital out completes with 0x55 and has no other effect. On any other subsystem it completes with 0xFF.
- R11: Every other command code (0, 2, 7, 8, 16–19, 32–38, 48 and all unlisted values), any subsystem code above 5, and read or write single on memory or counter complete with 0xFF. None of them changes parameter 2, `dout` or `run_en`.
- R12: After reset the mailbox reads 0x0000, and `cmd_done_irq`, `run_en`, `dout`, `conv_req` and `ao_wr_stb` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for `host_addr` |
| cmd_done_irq | output | 1 | Command-done flag |
| conv_req | output | 1 | Conversion request (valid) |
| conv_chan | output | AI_CH_W | Channel of the pending conversion |
| conv_gain | output | GAIN_W | Gain of the pending conversion |
| conv_vld | input | 1 | Converter result valid |
| conv_data | input | SAMPLE_W | Converter result |
| ao_wr_stb | output | 1 | Analog output write pulse |
| ao_chan | output | AO_CH_W | Analog output channel |
| ao_data | output | 16 | Analog output value |
| din | input | DIO_W | Digital input lines |
| dout | output | DIO_W | Digital output register |
| run_en | output | 2 | Run enables: bit 0 analog in, bit 1 analog out |

## Verification
The bench builds the block with `AI_CHANNELS`=16, `AO_CHANNELS`=2 and `CONV_TIMEOUT`=20. With these values the channel limits 15/16 and 1/2 are in reach of directed parameter values, and a silent converter runs into the abort after a short wait. A behavioural converter answers after three cycles with a sample that encodes channel and gain, so a wrong channel or gain routing shows up in parameter 2. Each mailbox write carries a nonzero high byte, which checks that the pending code is forced rather than copied.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;

    localparam int WORD_W = 16;

    // command codes acted upon
    localparam logic [7:0] OP_CONFIG  = 8'd1;
    localparam logic [7:0] OP_START   = 8'd3;
    localparam logic [7:0] OP_STOP    = 8'd4;
    localparam logic [7:0] OP_RD_ONE  = 8'd5;
    localparam logic [7:0] OP_WR_ONE  = 8'd6;

    // subsystem codes
    localparam logic [7:0] SS_ANA_IN  = 8'd0;
    localparam logic [7:0] SS_ANA_OUT = 8'd1;
    localparam logic [7:0] SS_DIG_IN  = 8'd2;
    localparam logic [7:0] SS_DIG_OUT = 8'd3;

    // completion codes (mailbox bits 15:8)
    localparam logic [7:0] DONE_PENDING = 8'h00;
    localparam logic [7:0] DONE_OK      = 8'h55;
    localparam logic [7:0] DONE_BADARG  = 8'hAA;
    localparam logic [7:0] DONE_UNSUP   = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_CONVERT
    } state_e;

    typedef enum logic [3:0] {
        ACT_UNSUP,
        ACT_BADARG,
        ACT_ACK,
        ACT_AI_READ,
        ACT_DIN_READ,
        ACT_AO_WRITE,
        ACT_DOUT_WRITE,
        ACT_RUN_ON,
        ACT_RUN_OFF
    } act_e;

endpackage

// File: rtl/mbx_cmd_decode.sv
`timescale 1ns/1ps
module mbx_cmd_decode
    import mbx_pkg::*;
#(
    parameter int AI_CHANNELS = 16,
    parameter int AO_CHANNELS = 2
) (
    input  logic [7:0]        cmd,
    input  logic [7:0]        sub,
    input  logic [WORD_W-1:0] chan,
    output act_e              act,
    output logic              run_idx
);

    logic ai_chan_ok;
    logic ao_chan_ok;

    always_comb begin
        ai_chan_ok = 32'(chan) < 32'(AI_CHANNELS);
        ao_chan_ok = 32'(chan) < 32'(AO_CHANNELS);
        act        = ACT_UNSUP;
        run_idx    = (sub == SS_ANA_OUT);
        case (cmd)
            OP_CONFIG: begin
                if (sub == SS_ANA_IN || sub == SS_ANA_OUT || sub == SS_DIG_OUT)
                    act = ACT_ACK;
            end
            OP_START: begin
                if (sub == SS_ANA_IN || sub == SS_ANA_OUT)
                    act = ACT_RUN_ON;
            end
            OP_STOP: begin
                if (sub == SS_ANA_IN || sub == SS_ANA_OUT)
                    act = ACT_RUN_OFF;
            end
            OP_RD_ONE: begin
                if (sub == SS_ANA_IN)
                    act = ai_chan_ok ? ACT_AI_READ : ACT_BADARG;
                else if (sub == SS_DIG_IN)
                    act = ACT_DIN_READ;
            end
            OP_WR_ONE: begin
                if (sub == SS_ANA_OUT)
                    act = ao_chan_ok ? ACT_AO_WRITE : ACT_BADARG;
                else if (sub == SS_DIG_OUT)
                    act = ACT_DOUT_WRITE;
            end
            default: act = ACT_UNSUP;
        endcase
    end

endmodule

// File: rtl/mbx_conv_timer.sv
`timescale 1ns/1ps
module mbx_conv_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d   = cnt_q;
        expired = active && (cnt_q == CW'(LIMIT - 1));
        if (!active || expired)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    // R3: the wait for a sample never runs past the limit
    a_r3_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT));

endmodule

// File: rtl/mbx_responder.sv
`timescale 1ns/1ps
module mbx_responder
    import mbx_pkg::*;
#(
    parameter int N_PARAM      = 8,
    parameter int AI_CHANNELS  = 16,
    parameter int AO_CHANNELS  = 2,
    parameter int DIO_W        = 8,
    parameter int SAMPLE_W     = 16,
    parameter int GAIN_W       = 2,
    parameter int CONV_TIMEOUT = 64,
    localparam int ADDR_W  = $clog2(N_PARAM + 2),
    localparam int AI_CH_W = (AI_CHANNELS > 1) ? $clog2(AI_CHANNELS) : 1,
    localparam int AO_CH_W = (AO_CHANNELS > 1) ? $clog2(AO_CHANNELS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [15:0]         host_wdata,
    output logic [15:0]         host_rdata,
    output logic                cmd_done_irq,
    output logic                conv_req,
    output logic [AI_CH_W-1:0]  conv_chan,
    output logic [GAIN_W-1:0]   conv_gain,
    input  logic                conv_vld,
    input  logic [SAMPLE_W-1:0] conv_data,
    output logic                ao_wr_stb,
    output logic [AO_CH_W-1:0]  ao_chan,
    output logic [15:0]         ao_data,
    input  logic [DIO_W-1:0]    din,
    output logic [DIO_W-1:0]    dout,
    output logic [1:0]          run_en
);

    localparam int P_CHAN = 0;
    localparam int P_GAIN = 1;
    localparam int P_DATA = 2;

    typedef struct packed {
        state_e                          st;
        logic [WORD_W-1:0]               mbx;
        logic [7:0]                      sub;
        logic [N_PARAM-1:0][WORD_W-1:0]  prm;
        logic                            irq;
        logic [1:0]                      run;
        logic [DIO_W-1:0]                dout;
        logic                            creq;
        logic [AI_CH_W-1:0]              cchan;
        logic [GAIN_W-1:0]               cgain;
        logic                            ao_stb;
        logic [AO_CH_W-1:0]              ao_ch;
        logic [WORD_W-1:0]               ao_val;
    } regs_t;

    regs_t q_d, q_q;

    act_e act;
    logic run_idx;
    logic tmo;
    logic mbx_wr;

    mbx_cmd_decode #(
        .AI_CHANNELS (AI_CHANNELS),
        .AO_CHANNELS (AO_CHANNELS)
    ) decode_i (
        .cmd     (q_q.mbx[7:0]),
        .sub     (q_q.sub),
        .chan    (q_q.prm[P_CHAN]),
        .act     (act),
        .run_idx (run_idx)
    );

    mbx_conv_timer #(
        .LIMIT (CONV_TIMEOUT)
    ) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (q_q.st == ST_CONVERT),
        .expired (tmo)
    );

    assign mbx_wr = host_we && (host_addr == ADDR_W'(0));

    always_comb begin
        q_d        = q_q;
        q_d.ao_stb = 1'b0;

        // command execution
        case (q_q.st)
            ST_DECODE: begin
                q_d.st  = ST_IDLE;
                q_d.irq = 1'b1;
                q_d.mbx[15:8] = DONE_OK;
                case (act)
                    ACT_AI_READ: begin
                        q_d.st    = ST_CONVERT;
                        q_d.irq   = 1'b0;
                        q_d.mbx[15:8] = DONE_PENDING;
                        q_d.creq  = 1'b1;
                        q_d.cchan = q_q.prm[P_CHAN][AI_CH_W-1:0];
                        q_d.cgain = q_q.prm[P_GAIN][GAIN_W-1:0];
                    end
                    ACT_DIN_READ:   q_d.prm[P_DATA] = WORD_W'(din);
                    ACT_AO_WRITE: begin
                        q_d.ao_stb = 1'b1;
                        q_d.ao_ch  = q_q.prm[P_CHAN][AO_CH_W-1:0];
                        q_d.ao_val = q_q.prm[P_DATA];
                    end
                    ACT_DOUT_WRITE: q_d.dout = q_q.prm[P_DATA][DIO_W-1:0];
                    ACT_RUN_ON:     q_d.run[run_idx] = 1'b1;
                    ACT_RUN_OFF:    q_d.run[run_idx] = 1'b0;
                    ACT_ACK:        q_d.mbx[15:8] = DONE_OK;
                    ACT_BADARG:     q_d.mbx[15:8] = DONE_BADARG;
                    default:        q_d.mbx[15:8] = DONE_UNSUP;
                endcase
            end
            ST_CONVERT: begin
                if (conv_vld) begin
                    q_d.prm[P_DATA] = WORD_W'(conv_data);
                    q_d.mbx[15:8]   = DONE_OK;
                    q_d.irq  = 1'b1;
                    q_d.creq = 1'b0;
                    q_d.st   = ST_IDLE;
                end else if (tmo) begin
                    q_d.mbx[15:8] = DONE_BADARG;
                    q_d.irq  = 1'b1;
                    q_d.creq = 1'b0;
                    q_d.st   = ST_IDLE;
                end
            end
            default: ;
        endcase

        // host writes take priority over a completion in the same cycle
        if (host_we) begin
            if (host_addr == ADDR_W'(0)) begin
                q_d.mbx  = {DONE_PENDING, host_wdata[7:0]};
                q_d.irq  = 1'b0;
                q_d.creq = 1'b0;
                q_d.st   = ST_DECODE;
            end else if (host_addr == ADDR_W'(1)) begin
                q_d.sub = host_wdata[7:0];
            end
            for (int k = 0; k < N_PARAM; k++) begin
                if (host_addr == ADDR_W'(k + 2))
                    q_d.prm[k] = host_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{st: ST_IDLE, default: '0};
        end else begin
            q_q <= q_d;
        end
    end

    // host read mux
    always_comb begin
        host_rdata = '0;
        if (host_addr == ADDR_W'(0))
            host_rdata = q_q.mbx;
        else if (host_addr == ADDR_W'(1))
            host_rdata = {8'h00, q_q.sub};
        for (int k = 0; k < N_PARAM; k++) begin
            if (host_addr == ADDR_W'(k + 2))
                host_rdata = q_q.prm[k];
        end
    end

    assign cmd_done_irq = q_q.irq;
    assign conv_req     = q_q.creq;
    assign conv_chan    = q_q.cchan;
    assign conv_gain    = q_q.cgain;
    assign ao_wr_stb    = q_q.ao_stb;
    assign ao_chan      = q_q.ao_ch;
    assign ao_data      = q_q.ao_val;
    assign dout         = q_q.dout;
    assign run_en       = q_q.run;

    // R1: a mailbox write leaves the command pending with the done flag low
    a_r1_write_makes_pending: assert property (@(posedge clk) disable iff (!rst_n)
        mbx_wr |=> (q_q.mbx[15:8] == DONE_PENDING) && !cmd_done_irq
                   && (q_q.mbx[7:0] == $past(host_wdata[7:0])));

    // R2: a raised done flag always carries one of the three final codes
    a_r2_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done_irq |-> (q_q.mbx[15:8] == DONE_OK || q_q.mbx[15:8] == DONE_BADARG
                          || q_q.mbx[15:8] == DONE_UNSUP));

    // R2: flag and code persist until the host writes the mailbox again
    a_r2_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done_irq && !mbx_wr) |=> cmd_done_irq && $stable(q_q.mbx));

    // R4: request, channel and gain stay put until the converter answers
    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_vld && !tmo && !mbx_wr)
            |=> conv_req && $stable(conv_chan) && $stable(conv_gain));

    // R7: an output strobe only comes with a successful completion
    a_r7_strobe_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
        ao_wr_stb |-> cmd_done_irq && (q_q.mbx[15:8] == DONE_OK));

    // R9: run enables move only together with a successful completion
    a_r9_run_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(run_en) |-> cmd_done_irq && (q_q.mbx[15:8] == DONE_OK));

endmodule

// File: tb/mbx_responder_tb_top.sv
`timescale 1ns/1ps
module mbx_responder_tb_top;

    localparam int N_PARAM  = 8;
    localparam int AI_CH    = 16;
    localparam int AO_CH    = 2;
    localparam int DIO_W    = 8;
    localparam int TMO      = 20;
    localparam int ADDR_W   = $clog2(N_PARAM + 2);
    localparam int BOUND    = TMO + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [15:0]       host_wdata = '0;
    logic [15:0]       host_rdata;
    logic              cmd_done_irq;
    logic              conv_req;
    logic [3:0]        conv_chan;
    logic [1:0]        conv_gain;
    logic              conv_vld = 1'b0;
    logic [15:0]       conv_data = '0;
    logic              ao_wr_stb;
    logic [0:0]        ao_chan;
    logic [15:0]       ao_data;
    logic [DIO_W-1:0]  din = 8'h5A;
    logic [DIO_W-1:0]  dout;
    logic [1:0]        run_en;

    int n_vec = 0;
    int n_bad = 0;
    bit mute = 1'b0;
    int stb_cnt = 0;
    logic [0:0]  stb_chan = '0;
    logic [15:0] stb_data = '0;

    always #2.5 clk = ~clk;

    mbx_responder #(
        .N_PARAM (N_PARAM), .AI_CHANNELS (AI_CH), .AO_CHANNELS (AO_CH),
        .DIO_W (DIO_W), .SAMPLE_W (16), .GAIN_W (2), .CONV_TIMEOUT (TMO)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .host_we (host_we), .host_addr (host_addr),
        .host_wdata (host_wdata), .host_rdata (host_rdata),
        .cmd_done_irq (cmd_done_irq), .conv_req (conv_req), .conv_chan (conv_chan),
        .conv_gain (conv_gain), .conv_vld (conv_vld), .conv_data (conv_data),
        .ao_wr_stb (ao_wr_stb), .ao_chan (ao_chan), .ao_data (ao_data),
        .din (din), .dout (dout), .run_en (run_en)
    );

    // converter model: answers three cycles into a request
    initial begin
        int wait_n = 0;
        forever begin
            @(negedge clk);
            conv_vld = 1'b0;
            if (conv_req && !mute) begin
                wait_n++;
                if (wait_n == 3) begin
                    conv_vld  = 1'b1;
                    conv_data = 16'hA000 | {8'h00, conv_chan, 2'b00, conv_gain};
                    wait_n    = 0;
                end
            end else begin
                wait_n = 0;
            end
        end
    end

    // analog output strobe monitor
    always @(negedge clk) begin
        if (ao_wr_stb) begin
            stb_cnt++;
            stb_chan = ao_chan;
            stb_data = ao_data;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic host_write(input int a, input logic [15:0] d);
        @(negedge clk);
        host_we    = 1'b1;
        host_addr  = ADDR_W'(a);
        host_wdata = d;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic host_read(input int a, output logic [15:0] d);
        host_addr = ADDR_W'(a);
        #1;
        d = host_rdata;
    endtask

    task automatic run_cmd(input string tag, input logic [7:0] sub,
                           input logic [15:0] p0, input logic [15:0] p1,
                           input logic [15:0] p2, input logic [7:0] cmd,
                           input logic [7:0] exp_st, input logic [15:0] exp_p2,
                           input logic [1:0] exp_run, input logic [7:0] exp_dout);
        logic [15:0] rd;
        int cyc;
        host_write(1, {8'h00, sub});
        host_write(2, p0);
        host_write(3, p1);
        host_write(4, p2);
        host_write(0, {8'hC7, cmd});
        host_read(0, rd);
        chk({tag, " R1 pending"}, rd, {8'h00, cmd});
        chk({tag, " R1 irq low"}, {15'd0, cmd_done_irq}, 16'd0);
        cyc = 0;
        while (rd[15:8] == 8'h00 && cyc < 200) begin
            @(negedge clk);
            cyc++;
            host_read(0, rd);
        end
        chk({tag, " R3 bound"}, 16'(cyc > BOUND), 16'd0);
        chk({tag, " R2 status"}, {8'h00, rd[15:8]}, {8'h00, exp_st});
        chk({tag, " R2 irq"}, {15'd0, cmd_done_irq}, 16'd1);
        repeat (2) @(negedge clk);
        host_read(0, rd);
        chk({tag, " R2 held"}, rd, {exp_st, cmd});
        host_read(4, rd);
        chk({tag, " p2"}, rd, exp_p2);
        chk({tag, " run"}, {14'd0, run_en}, {14'd0, exp_run});
        chk({tag, " dout"}, {8'd0, dout}, {8'd0, exp_dout});
    endtask

    typedef struct packed {
        logic [7:0]  sub;
        logic [15:0] p0;
        logic [15:0] p1;
        logic [15:0] p2;
        logic [7:0]  cmd;
        logic [7:0]  st;
        logic [15:0] ep2;
        logic [1:0]  run;
        logic [7:0]  dout;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{8'd0, 16'd3,  16'd1, 16'h1111, 8'd5,  8'h55, 16'hA031, 2'b00, 8'h00}, // R4
        '{8'd0, 16'd15, 16'd7, 16'h1111, 8'd5,  8'h55, 16'hA0F3, 2'b00, 8'h00}, // R4 top channel
        '{8'd0, 16'd16, 16'd0, 16'h2222, 8'd5,  8'hAA, 16'h2222, 2'b00, 8'h00}, // R5
        '{8'd2, 16'd0,  16'd0, 16'h3333, 8'd5,  8'h55, 16'h005A, 2'b00, 8'h00}, // R6
        '{8'd3, 16'd0,  16'd0, 16'h00C3, 8'd6,  8'h55, 16'h00C3, 2'b00, 8'hC3}, // R8
        '{8'd0, 16'd0,  16'd0, 16'h0000, 8'd3,  8'h55, 16'h0000, 2'b01, 8'hC3}, // R9 start AI
        '{8'd1, 16'd0,  16'd0, 16'h0000, 8'd3,  8'h55, 16'h0000, 2'b11, 8'hC3}, // R9 start AO
        '{8'd0, 16'd0,  16'd0, 16'h0000, 8'd4,  8'h55, 16'h0000, 2'b10, 8'hC3}, // R9 stop AI
        '{8'd2, 16'd0,  16'd0, 16'h0000, 8'd3,  8'hFF, 16'h0000, 2'b10, 8'hC3}, // R9 start DIN
        '{8'd0, 16'd0,  16'd0, 16'h4444, 8'd1,  8'h55, 16'h4444, 2'b10, 8'hC3}, // R10
        '{8'd2, 16'd0,  16'd0, 16'h4444, 8'd1,  8'hFF, 16'h4444, 2'b10, 8'hC3}, // R10 DIN
        '{8'd0, 16'd0,  16'd0, 16'h5555, 8'd0,  8'hFF, 16'h5555, 2'b10, 8'hC3}, // R11 board info
        '{8'd0, 16'd0,  16'd0, 16'h5555, 8'd7,  8'hFF, 16'h5555, 2'b10, 8'hC3}, // R11 clock calc
        '{8'd0, 16'd0,  16'd0, 16'h5555, 8'd48, 8'hFF, 16'h5555, 2'b10, 8'hC3}, // R11 halt
        '{8'd0, 16'd0,  16'd0, 16'h5555, 8'd9,  8'hFF, 16'h5555, 2'b10, 8'hC3}, // R11 unlisted
        '{8'd4, 16'd0,  16'd0, 16'h6666, 8'd5,  8'hFF, 16'h6666, 2'b10, 8'hC3}, // R11 memory read
        '{8'd6, 16'd0,  16'd0, 16'h6666, 8'd5,  8'hFF, 16'h6666, 2'b10, 8'hC3}, // R11 bad subsystem
        '{8'd3, 16'd0,  16'd0, 16'h1F3C, 8'd6,  8'h55, 16'h1F3C, 2'b10, 8'h3C}, // R8 truncation
        '{8'd1, 16'd0,  16'd0, 16'h0000, 8'd4,  8'h55, 16'h0000, 2'b00, 8'h3C}, // R9 stop AO
        '{8'd1, 16'd1,  16'd0, 16'h0ABC, 8'd6,  8'h55, 16'h0ABC, 2'b00, 8'h3C}, // R7 top channel
        '{8'd1, 16'd2,  16'd0, 16'h0DEF, 8'd6,  8'hAA, 16'h0DEF, 2'b00, 8'h3C}  // R7 out of range
    };

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        host_read(0, rd);
        chk("R12 mailbox", rd, 16'h0000);
        chk("R12 irq", {15'd0, cmd_done_irq}, 16'd0);
        chk("R12 run", {14'd0, run_en}, 16'd0);
        chk("R12 dout", {8'd0, dout}, 16'd0);
        chk("R12 req/stb", {14'd0, conv_req, ao_wr_stb}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            run_cmd($sformatf("vec%0d", i), VEC[i].sub, VEC[i].p0, VEC[i].p1,
                    VEC[i].p2, VEC[i].cmd, VEC[i].st, VEC[i].ep2,
                    VEC[i].run, VEC[i].dout);
        end

        // R7: exactly one strobe, carrying channel 1 and its data
        chk("R7 strobe count", 16'(stb_cnt), 16'd1);
        chk("R7 strobe chan", {15'd0, stb_chan}, 16'd1);
        chk("R7 strobe data", stb_data, 16'h0ABC);

        // R3: silent converter aborts with 0xAA and releases the request
        mute = 1'b1;
        run_cmd("R3 timeout", 8'd0, 16'd2, 16'd0, 16'h7777, 8'd5,
                8'hAA, 16'h7777, 2'b00, 8'h3C);
        chk("R3 req dropped", {15'd0, conv_req}, 16'd0);
        mute = 1'b0;

        // R5: bad channel raises no request
        host_write(1, 16'd0);
        host_write(2, 16'd200);
        host_write(0, 16'h0005);
        chk("R5 no request", {15'd0, conv_req}, 16'd0);
        @(negedge clk);
        chk("R5 no request later", {15'd0, conv_req}, 16'd0);

        finish_run();
    end

endmodule